// File: doc/BRIEF.md
# Format-Selectable Serial Transmit Port

This block turns a 13-bit two's complement conversion result into a 16-bit serial frame on a pin that can be released to high impedance. The result arrives on a parallel input and is captured into a holding latch on an update strobe. A transmit enable, a transmit data clock and a format select come in from outside. All three are synchronised into the system clock domain and edge-detected there.

When a transfer starts, the held sample is packed into one of two 16-bit layouts and loaded into a rotating shift register. Packing 0 puts the sign extension in front. Packing 1 puts the sign padding behind. One bit leaves on each rising edge of the transmit clock while the enable stays high. If the transmit clock is already high when the enable rises, the enable edge itself launches the first bit. If the enable is held longer than a frame, the frame is sent again from its first bit. The output-enable signal stands for the three-state control of the pin.

Top module: `txser_port`

## Requirements
- R1: With fmt_sel = 0 at the start of a transfer, the 16 bits leave in this order: the sign bit (smp_data[12]) four times, then smp_data[11] down to smp_data[0].
- R2: With fmt_sel = 1 at the start of a transfer, the 16 bits leave in this order: smp_data[12], then smp_data[11] down to smp_data[0], then smp_data[12] three more times.
- R3: ser_oe is 0 while the synchronised enable is low and 1 while it is high.
- R4: If xmit_clk is low when xmit_en rises, ser_out carries the first frame bit after the first rising xmit_clk edge.
- R5: If xmit_clk is high when xmit_en rises, ser_out carries the first frame bit from the enable edge, and the next rising xmit_clk edge moves it to the second bit.
- R6: After the 16th bit, further rising xmit_clk edges with xmit_en still high send the same frame again, starting with its first bit.
- R7: The frame is fixed when the transfer starts. A change of fmt_sel or a strobe on smp_stb during the transfer does not alter the bits that follow in that transfer.
- R8: The holding latch keeps the last value strobed by smp_stb. A sample strobed during a transfer is the one sent by the next transfer.
- R9: After reset, ser_oe and ser_out are both 0.
- R10: A change on xmit_en or xmit_clk driven between system clock edges reaches ser_oe or ser_out after the third rising system clock edge that follows it. Two of those edges are synchroniser stages and one is the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | 13 | Conversion result, two's complement |
| smp_stb | input | 1 | Captures smp_data into the holding latch |
| xmit_en | input | 1 | Transmit enable; also controls the output drive |
| xmit_clk | input | 1 | Transmit data clock; a bit leaves on each rising edge |
| fmt_sel | input | 1 | Frame packing: 0 sign in front, 1 sign padding behind |
| ser_out | output | 1 | Serial frame bit |
| ser_oe | output | 1 | Output drive enable; 0 means the pin is high impedance |

## Verification
The bench uses the default parameters: a 13-bit sample, a 16-bit frame and two synchroniser stages. At this size each frame can be followed bit by bit through its first recirculation. The sweep covers extreme, zero, alternating and single-bit samples under both packings, each started with the transmit clock low and with it high. Holding every external edge for several system cycles makes the three-cycle latency exact, so that latency is checked on its own and mid-transfer format and strobe changes can be placed at known bit positions.

// File: rtl/txser_pkg.sv
package txser_pkg;
  localparam int SMP_W_DEF = 13;
  localparam int FRM_W_DEF = 16;
  localparam int SYNC_DEF  = 2;

  typedef struct packed {
    logic en;
    logic dclk;
    logic fmt;
  } txser_ctl_t;
endpackage

// File: rtl/txser_sync.sv
module txser_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign d_sync[b] = chain[LAST];
  end
endmodule

// File: rtl/txser_hold.sv
module txser_hold #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (stb) q <= d;
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(stb) |-> $stable(q));
endmodule

// File: rtl/txser_frame.sv
module txser_frame #(
  parameter int SMP_W = 13,
  parameter int FRM_W = 16
) (
  input  logic [SMP_W-1:0] smp,
  input  logic             fmt,
  output logic [FRM_W-1:0] frame
);
  localparam int PAD = FRM_W - SMP_W;

  logic sgn;
  assign sgn = smp[SMP_W-1];

  always_comb begin
    if (fmt) frame = {smp, {PAD{sgn}}};
    else     frame = {{PAD{sgn}}, smp};
  end
endmodule

// File: rtl/txser_shift.sv
module txser_shift #(
  parameter int FRM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_s,
  input  logic             dclk_s,
  input  logic [FRM_W-1:0] frame,
  output logic             bit_out,
  output logic             oe_out,
  output logic             active
);
  localparam int TOP = FRM_W - 1;

  logic             en_d, dclk_d, loaded, oe_q;
  logic [FRM_W-1:0] sh;
  logic             en_rise, dclk_rise, load, step;

  assign en_rise   = en_s & ~en_d;
  assign dclk_rise = dclk_s & ~dclk_d;
  assign load      = en_s & ~loaded & dclk_s & (en_rise | dclk_rise);
  assign step      = en_s & loaded & dclk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= 1'b0;
      dclk_d <= 1'b0;
      oe_q   <= 1'b0;
      loaded <= 1'b0;
      sh     <= '0;
    end else begin
      en_d   <= en_s;
      dclk_d <= dclk_s;
      oe_q   <= en_s;
      if (!en_s)     loaded <= 1'b0;
      else if (load) loaded <= 1'b1;
      if (load)      sh <= frame;
      else if (step) sh <= {sh[TOP-1:0], sh[TOP]};
    end
  end

  assign bit_out = sh[TOP];
  assign oe_out  = oe_q;
  assign active  = loaded;

  // R7
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(loaded) |-> (sh == $past(frame)));

  // R4
  load_coincide_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(loaded) |-> ($past(en_s) && $past(dclk_s)));

  // R6
  rotate_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (loaded && $past(loaded)) |-> ($countones(sh) == $countones($past(sh))));
endmodule

// File: rtl/txser_port.sv
module txser_port
  import txser_pkg::*;
#(
  parameter int SMP_W       = SMP_W_DEF,
  parameter int FRM_W       = FRM_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_stb,
  input  logic             xmit_en,
  input  logic             xmit_clk,
  input  logic             fmt_sel,
  output logic             ser_out,
  output logic             ser_oe
);
  localparam int CTL_W = $bits(txser_ctl_t);

  txser_ctl_t       ctl_a, ctl_s;
  logic [SMP_W-1:0] held;
  logic [FRM_W-1:0] frame;
  logic             active;

  assign ctl_a = '{en: xmit_en, dclk: xmit_clk, fmt: fmt_sel};

  txser_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d_async(ctl_a), .d_sync(ctl_s)
  );

  txser_hold #(.W(SMP_W)) i_hold (
    .clk(clk), .rst(rst), .stb(smp_stb), .d(smp_data), .q(held)
  );

  txser_frame #(.SMP_W(SMP_W), .FRM_W(FRM_W)) i_frame (
    .smp(held), .fmt(ctl_s.fmt), .frame(frame)
  );

  txser_shift #(.FRM_W(FRM_W)) i_shift (
    .clk(clk), .rst(rst), .en_s(ctl_s.en), .dclk_s(ctl_s.dclk),
    .frame(frame), .bit_out(ser_out), .oe_out(ser_oe), .active(active)
  );

  // R3
  idle_when_released_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_oe |-> !active);
endmodule

// File: tb/test_txser_port.sv
module test_txser_port;
  localparam int CLK_PER = 10;
  localparam int SETTLE  = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] smp_data = '0;
  logic        smp_stb = 1'b0;
  logic        xmit_en = 1'b0;
  logic        xmit_clk = 1'b0;
  logic        fmt_sel = 1'b0;
  logic        ser_out, ser_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  txser_port i_txser_port (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_stb(smp_stb),
    .xmit_en(xmit_en), .xmit_clk(xmit_clk), .fmt_sel(fmt_sel),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  function automatic int pack(input int v, input bit fmt);
    int neg;
    neg = (v < 0) ? 1 : 0;
    if (fmt) return ((v * 8) + (neg ? 7 : 0)) & 16'hFFFF;
    return v & 16'hFFFF;
  endfunction

  task automatic strobe(input int v);
    @(negedge clk);
    smp_data = v[12:0];
    smp_stb  = 1'b1;
    @(negedge clk);
    smp_stb  = 1'b0;
  endtask

  // full transfer of nb bits, checking every bit
  task automatic run_frame(input int v, input bit fmt, input bit hi_start, input int nb);
    int exp;
    exp = pack(v, fmt);
    strobe(v);
    fmt_sel = fmt;
    xmit_clk = hi_start;
    settle();
    xmit_en = 1'b1;
    settle();
    chk("R3 oe high", ser_oe, 1);
    for (int k = 0; k < nb; k++) begin
      string tag;
      if (k >= 16)    tag = "R6 recirculate";
      else if (fmt)   tag = "R2 pack1";
      else            tag = "R1 pack0";
      if (k == 0 && hi_start) begin
        chk("R5 first bit on enable", ser_out, (exp >> 15) & 1);
      end else begin
        if (hi_start) begin
          xmit_clk = 1'b0; settle();
          xmit_clk = 1'b1; settle();
        end else begin
          xmit_clk = 1'b1; settle();
        end
        if (k == 0) chk("R4 first bit on clock", ser_out, (exp >> 15) & 1);
        else        chk(tag, ser_out, (exp >> (15 - (k % 16))) & 1);
        if (!hi_start) begin
          xmit_clk = 1'b0; settle();
        end
      end
    end
    xmit_en = 1'b0;
    xmit_clk = 1'b0;
    settle();
    chk("R3 oe low", ser_oe, 0);
  endtask

  initial begin
    int vals[7] = '{-4096, 4095, 0, -1, -2, 1365, -1366};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 oe after reset", ser_oe, 0);
    chk("R9 out after reset", ser_out, 0);

    // R10 latency of the enable path
    @(negedge clk);
    xmit_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 oe not yet", ser_oe, 0);
    @(negedge clk);
    chk("R10 oe after three edges", ser_oe, 1);
    xmit_en = 1'b0;
    settle();
    chk("R3 oe low idle", ser_oe, 0);

    // sweep: samples x packing x start phase
    for (int i = 0; i < 7; i++)
      for (int f = 0; f < 2; f++)
        for (int h = 0; h < 2; h++)
          run_frame(vals[i], f[0], h[0], 20);
    for (int i = 0; i < 12; i++)
      for (int f = 0; f < 2; f++)
        for (int h = 0; h < 2; h++)
          run_frame(1 << i, f[0], h[0], 18);

    // R10 latency of the data clock path
    begin
      int e;
      e = pack(-4096, 1'b0);
      strobe(-4096);
      fmt_sel = 1'b0;
      xmit_clk = 1'b0;
      settle();
      xmit_en = 1'b1;
      settle();
      xmit_clk = 1'b1; settle();
      xmit_clk = 1'b0; settle();
      xmit_clk = 1'b1; settle();
      xmit_clk = 1'b0; settle();
      xmit_clk = 1'b1; settle();
      xmit_clk = 1'b0; settle();
      xmit_clk = 1'b1; settle();
      xmit_clk = 1'b0; settle();
      // next bit (index 4) is 0, current (index 3) is 1
      chk("R10 bit before edge", ser_out, (e >> 12) & 1);
      @(negedge clk);
      xmit_clk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R10 bit held two edges", ser_out, (e >> 12) & 1);
      @(negedge clk);
      chk("R10 bit after three edges", ser_out, (e >> 11) & 1);
      xmit_clk = 1'b0;
      xmit_en = 1'b0;
      settle();
    end

    // R7 / R8: mid-transfer format change and strobe
    begin
      int a, b, ea, eb;
      a = -1366; b = 1365;
      ea = pack(a, 1'b0);
      eb = pack(b, 1'b1);
      strobe(a);
      fmt_sel = 1'b0;
      xmit_clk = 1'b0;
      settle();
      xmit_en = 1'b1;
      settle();
      for (int k = 0; k < 16; k++) begin
        xmit_clk = 1'b1; settle();
        chk("R7 frame fixed", ser_out, (ea >> (15 - k)) & 1);
        xmit_clk = 1'b0; settle();
        if (k == 5) begin
          fmt_sel = 1'b1;
          strobe(b);
          settle();
        end
      end
      xmit_en = 1'b0;
      settle();
      xmit_en = 1'b1;
      settle();
      for (int k = 0; k < 16; k++) begin
        xmit_clk = 1'b1; settle();
        chk("R8 next transfer uses new sample", ser_out, (eb >> (15 - k)) & 1);
        xmit_clk = 1'b0; settle();
      end
      xmit_en = 1'b0;
      settle();
      chk("R3 oe low end", ser_oe, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PER * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule